// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Network

This block sits in the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). The register file has already been read for the two source register IDs of the decoding instruction. That read data can be stale when an older instruction still in flight is going to write the same register. The block compares each source ID against the destination IDs of five result taps from later stages. It replaces the stale value with the youngest matching result, so that the execute pipeline register latches correct operands on the next edge.

Forwarding here is pure datapath. The selection reads only the stage write enables, destination IDs, load flags and result values. It never reads any stall or bubble state of the pipeline control. A load whose data has not left the execute stage cannot be forwarded. In that case the block raises `load_use_stall`, a combinational flag, and the control unit inserts the single bubble.

The taps, from youngest to oldest, are:

| Tap | Name in the design | Source |
|-----|--------------------|--------|
| EX | `SRC_EX` | execute ALU output |
| MEMIN | `SRC_MEMIN` | memory-stage input, the ALU value of a non-load |
| MEMOUT | `SRC_MEMOUT` | memory-stage output, the load data |
| WBIN | `SRC_WBIN` | writeback-stage input |
| WBOUT | `SRC_WBOUT` | writeback-stage output, the retiring write |

When no tap matches, the selection falls back to `SRC_RF`, the register-file read data. The block has no state and no state transitions.

Top module: `decode_bypass_net`

## Requirements
- R1: Register ID 0 is the reserved "no register" ID. A source ID of 0 never matches any tap, even with the write enable set and a destination ID of 0. The operand is then the register-file read data.
- R2: When no tap matches a source ID, the operand equals that source's register-file read data.
- R3: When the execute stage holds a non-load with `ex_we`=1 and `ex_rd` equal to the source ID, the operand is `ex_result`. This covers a back-to-back dependence with no lost cycle.
- R4: A matching memory-stage instruction with `mem_is_load`=0 supplies `mem_alu`. With `mem_is_load`=1 it supplies `mem_load_data`. This covers a dependence at distance one.
- R5: A matching writeback-stage input supplies `wb_data`, and a matching retiring write supplies `ret_data`. This covers a dependence at distance two.
- R6: When several taps match the same source ID, the youngest wins. The order is execute, then memory, then writeback input, then writeback output, then the register file.
- R7: `load_use_stall` is 1 when the execute stage holds a load (`ex_we`=1, `ex_is_load`=1) whose nonzero `ex_rd` equals either source ID. The execute-stage value is then never forwarded. The operand comes from the next matching older tap, or from the register file.
- R8: `load_use_stall` is 0 when the execute instruction is not a load, does not write, targets register 0, or matches neither source ID.
- R9: The two operands are selected independently. Each may come from a different tap in the same cycle.
- R10: A tap whose write enable is 0 never supplies a value, even when its destination ID matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_src_a | input | RID_W | first source register ID in decode |
| dec_src_b | input | RID_W | second source register ID in decode |
| rf_data_a | input | XLEN | register-file read data for source A |
| rf_data_b | input | XLEN | register-file read data for source B |
| ex_we | input | 1 | execute-stage instruction writes a register |
| ex_is_load | input | 1 | execute-stage instruction is a load |
| ex_rd | input | RID_W | execute-stage destination ID |
| ex_result | input | XLEN | execute ALU output |
| mem_we | input | 1 | memory-stage instruction writes a register |
| mem_is_load | input | 1 | memory-stage instruction is a load |
| mem_rd | input | RID_W | memory-stage destination ID |
| mem_alu | input | XLEN | value held at the memory-stage input |
| mem_load_data | input | XLEN | load data at the memory-stage output |
| wb_we | input | 1 | writeback-stage input writes a register |
| wb_rd | input | RID_W | writeback-stage destination ID |
| wb_data | input | XLEN | writeback-stage input value |
| ret_we | input | 1 | retiring write at the writeback output is valid |
| ret_rd | input | RID_W | retiring write destination ID |
| ret_data | input | XLEN | retiring write value |
| opnd_a | output | XLEN | corrected operand A |
| opnd_b | output | XLEN | corrected operand B |
| load_use_stall | output | 1 | load in execute feeds a decode source |

## Verification
Two functions can fall in the same cycle. A load-use stall can be raised while an older tap still forwards a value for the same register. Also, one operand can take an execute-stage value while the other takes a memory-stage value. The bench provokes the first by placing a load to register 8 in execute and a non-load to register 8 in memory. It then expects the stall flag together with the memory value on the operand. It provokes the second by pointing the two sources at different in-flight producers, and judges each operand against its own expected tap.

// File: rtl/byp_pkg.sv
package byp_pkg;

    localparam int NUM_TAPS = 5;
    localparam int SEL_W    = $clog2(NUM_TAPS + 1);

    // Encoding order is the priority order: lower value = younger producer.
    typedef enum logic [SEL_W-1:0] {
        SRC_EX     = 3'd0,
        SRC_MEMIN  = 3'd1,
        SRC_MEMOUT = 3'd2,
        SRC_WBIN   = 3'd3,
        SRC_WBOUT  = 3'd4,
        SRC_RF     = 3'd5
    } byp_src_e;

endpackage

// File: rtl/byp_tap_match.sv
module byp_tap_match
    import byp_pkg::*;
#(
    parameter int RID_W  = 5,
    parameter int NO_REG = 0
) (
    input  logic [RID_W-1:0]                src_id,
    input  logic [NUM_TAPS-1:0]             tap_valid,
    input  logic [NUM_TAPS-1:0][RID_W-1:0]  tap_rd,
    output logic [NUM_TAPS-1:0]             hit
);

    localparam logic [RID_W-1:0] NONE_ID = RID_W'(NO_REG);

    logic src_real;
    assign src_real = (src_id != NONE_ID);

    for (genvar t = 0; t < NUM_TAPS; t++) begin : gen_cmp
        assign hit[t] = tap_valid[t] && src_real && (tap_rd[t] == src_id);
    end

endmodule

// File: rtl/byp_prio_sel.sv
module byp_prio_sel
    import byp_pkg::*;
(
    input  logic [NUM_TAPS-1:0] hit,
    output byp_src_e            sel
);

    always_comb begin
        sel = SRC_RF;
        for (int t = NUM_TAPS - 1; t >= 0; t--) begin
            if (hit[t]) begin
                sel = byp_src_e'(SEL_W'(t));
            end
        end
    end

    // R6: a tap is chosen only when it matched, and a match never falls to RF
    always_comb begin
        if (sel != SRC_RF) begin
            a_r6_sel_matches: assert (hit[sel]) else $error("R6 selected tap did not match");
        end
        if (hit != '0) begin
            a_r6_hit_not_rf: assert (sel != SRC_RF) else $error("R6 matching tap ignored");
        end
    end

endmodule

// File: rtl/byp_operand_mux.sv
module byp_operand_mux
    import byp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  byp_src_e                       sel,
    input  logic [NUM_TAPS-1:0][XLEN-1:0]  tap_data,
    input  logic [XLEN-1:0]                rf_data,
    output logic [XLEN-1:0]                opnd
);

    always_comb begin
        opnd = rf_data;
        for (int t = 0; t < NUM_TAPS; t++) begin
            if (sel == byp_src_e'(SEL_W'(t))) begin
                opnd = tap_data[t];
            end
        end
    end

endmodule

// File: rtl/byp_load_use.sv
module byp_load_use #(
    parameter int RID_W  = 5,
    parameter int NO_REG = 0
) (
    input  logic             ex_we,
    input  logic             ex_is_load,
    input  logic [RID_W-1:0] ex_rd,
    input  logic [RID_W-1:0] src_a,
    input  logic [RID_W-1:0] src_b,
    output logic             stall
);

    localparam logic [RID_W-1:0] NONE_ID = RID_W'(NO_REG);

    logic pending_load;
    assign pending_load = ex_we && ex_is_load && (ex_rd != NONE_ID);
    assign stall = pending_load && ((ex_rd == src_a) || (ex_rd == src_b));

endmodule

// File: rtl/decode_bypass_net.sv
module decode_bypass_net
    import byp_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int RID_W = 5
) (
    input  logic [RID_W-1:0] dec_src_a,
    input  logic [RID_W-1:0] dec_src_b,
    input  logic [XLEN-1:0]  rf_data_a,
    input  logic [XLEN-1:0]  rf_data_b,
    input  logic             ex_we,
    input  logic             ex_is_load,
    input  logic [RID_W-1:0] ex_rd,
    input  logic [XLEN-1:0]  ex_result,
    input  logic             mem_we,
    input  logic             mem_is_load,
    input  logic [RID_W-1:0] mem_rd,
    input  logic [XLEN-1:0]  mem_alu,
    input  logic [XLEN-1:0]  mem_load_data,
    input  logic             wb_we,
    input  logic [RID_W-1:0] wb_rd,
    input  logic [XLEN-1:0]  wb_data,
    input  logic             ret_we,
    input  logic [RID_W-1:0] ret_rd,
    input  logic [XLEN-1:0]  ret_data,
    output logic [XLEN-1:0]  opnd_a,
    output logic [XLEN-1:0]  opnd_b,
    output logic             load_use_stall
);

    localparam int NO_REG  = 0;
    localparam int NUM_OPS = 2;

    // Tap table, index = priority (0 = youngest)
    logic [NUM_TAPS-1:0]            tap_valid;
    logic [NUM_TAPS-1:0][RID_W-1:0] tap_rd;
    logic [NUM_TAPS-1:0][XLEN-1:0]  tap_data;

    assign tap_valid = {ret_we, wb_we, mem_we & mem_is_load,
                        mem_we & ~mem_is_load, ex_we & ~ex_is_load};
    assign tap_rd    = {ret_rd, wb_rd, mem_rd, mem_rd, ex_rd};
    assign tap_data  = {ret_data, wb_data, mem_load_data, mem_alu, ex_result};

    logic [NUM_OPS-1:0][RID_W-1:0] src_id;
    logic [NUM_OPS-1:0][XLEN-1:0]  rf_rd;
    logic [NUM_OPS-1:0][XLEN-1:0]  opnd;

    assign src_id = {dec_src_b, dec_src_a};
    assign rf_rd  = {rf_data_b, rf_data_a};

    for (genvar i = 0; i < NUM_OPS; i++) begin : gen_opnd
        logic [NUM_TAPS-1:0] hit;
        byp_src_e            sel;

        byp_tap_match #(.RID_W(RID_W), .NO_REG(NO_REG)) u_match (
            .src_id    (src_id[i]),
            .tap_valid (tap_valid),
            .tap_rd    (tap_rd),
            .hit       (hit)
        );

        byp_prio_sel u_prio (
            .hit (hit),
            .sel (sel)
        );

        byp_operand_mux #(.XLEN(XLEN)) u_mux (
            .sel      (sel),
            .tap_data (tap_data),
            .rf_data  (rf_rd[i]),
            .opnd     (opnd[i])
        );

        always_comb begin
            // R1: the reserved ID always reads the register file
            if (src_id[i] == RID_W'(NO_REG)) begin
                a_r1_none_reads_rf: assert (opnd[i] == rf_rd[i])
                    else $error("R1 reserved ID forwarded");
            end
            // R7: a load in execute is never the forwarding source
            if (ex_is_load) begin
                a_r7_no_ex_load_fwd: assert (sel != SRC_EX)
                    else $error("R7 load value forwarded from execute");
            end
            // R3: a writing non-load in execute owns a matching source
            if (ex_we && !ex_is_load && (ex_rd == src_id[i])
                && (src_id[i] != RID_W'(NO_REG))) begin
                a_r3_ex_wins: assert (opnd[i] == ex_result)
                    else $error("R3 execute result not forwarded");
            end
        end
    end

    assign opnd_a = opnd[0];
    assign opnd_b = opnd[1];

    byp_load_use #(.RID_W(RID_W), .NO_REG(NO_REG)) u_lu (
        .ex_we      (ex_we),
        .ex_is_load (ex_is_load),
        .ex_rd      (ex_rd),
        .src_a      (dec_src_a),
        .src_b      (dec_src_b),
        .stall      (load_use_stall)
    );

    // R8: a stall implies a writing load in execute aimed at a decode source
    always_comb begin
        if (load_use_stall) begin
            a_r8_stall_cause: assert (ex_we && ex_is_load
                && ((ex_rd == dec_src_a) || (ex_rd == dec_src_b)))
                else $error("R8 stall without load-use cause");
        end
    end

endmodule

// File: tb/tb_decode_bypass_net.sv
`timescale 1ns/1ps
module tb_decode_bypass_net;

    localparam int XLEN  = 32;
    localparam int RID_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [RID_W-1:0] dec_src_a, dec_src_b, ex_rd, mem_rd, wb_rd, ret_rd;
    logic [XLEN-1:0]  rf_data_a, rf_data_b, ex_result, mem_alu, mem_load_data;
    logic [XLEN-1:0]  wb_data, ret_data, opnd_a, opnd_b;
    logic             ex_we, ex_is_load, mem_we, mem_is_load, wb_we, ret_we;
    logic             load_use_stall;

    decode_bypass_net #(.XLEN(XLEN), .RID_W(RID_W)) dut (
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .rf_data_a(rf_data_a), .rf_data_b(rf_data_b),
        .ex_we(ex_we), .ex_is_load(ex_is_load), .ex_rd(ex_rd), .ex_result(ex_result),
        .mem_we(mem_we), .mem_is_load(mem_is_load), .mem_rd(mem_rd),
        .mem_alu(mem_alu), .mem_load_data(mem_load_data),
        .wb_we(wb_we), .wb_rd(wb_rd), .wb_data(wb_data),
        .ret_we(ret_we), .ret_rd(ret_rd), .ret_data(ret_data),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .load_use_stall(load_use_stall)
    );

    typedef struct {
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic            s;
        string           req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    task automatic clear_taps();
        ex_we = 0; ex_is_load = 0; ex_rd = 0; ex_result = 0;
        mem_we = 0; mem_is_load = 0; mem_rd = 0; mem_alu = 0; mem_load_data = 0;
        wb_we = 0; wb_rd = 0; wb_data = 0;
        ret_we = 0; ret_rd = 0; ret_data = 0;
    endtask

    // Driver: present one decode cycle and queue its expected outputs
    task automatic apply(input logic [RID_W-1:0] sa, input logic [RID_W-1:0] sb,
                         input logic [XLEN-1:0] ra, input logic [XLEN-1:0] rb,
                         input logic [XLEN-1:0] ea, input logic [XLEN-1:0] eb,
                         input logic es, input string req);
        exp_t e;
        @(posedge clk);
        #1;
        dec_src_a = sa; dec_src_b = sb; rf_data_a = ra; rf_data_b = rb;
        e.a = ea; e.b = eb; e.s = es; e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic cmp(input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp,
                       input string what, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: scoreboard pops at the falling edge, mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                cmp(opnd_a, e.a, "opnd_a", e.req);
                cmp(opnd_b, e.b, "opnd_b", e.req);
                cmp({31'd0, load_use_stall}, {31'd0, e.s}, "stall", e.req);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_taps();
        dec_src_a = 0; dec_src_b = 0; rf_data_a = 0; rf_data_b = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset / idle state, R2
        apply(0, 0, 0, 0, 0, 0, 0, "R2 idle");
        // R2: no match reads RF
        apply(3, 4, 32'h33, 32'h44, 32'h33, 32'h44, 0, "R2");

        // R10: matching IDs but write enables low
        ex_rd = 3; ex_result = 32'hBAD0; mem_rd = 4; mem_alu = 32'hBAD1;
        wb_rd = 3; wb_data = 32'hBAD2; ret_rd = 4; ret_data = 32'hBAD3;
        apply(3, 4, 32'h33, 32'h44, 32'h33, 32'h44, 0, "R10");
        clear_taps();

        // R3: back-to-back dependence
        ex_we = 1; ex_rd = 3; ex_result = 32'hAAAA;
        apply(3, 4, 32'h33, 32'h44, 32'hAAAA, 32'h44, 0, "R3");
        clear_taps();

        // R4: distance one, ALU value then load data
        mem_we = 1; mem_rd = 4; mem_alu = 32'hBBBB; mem_load_data = 32'hDEAD;
        apply(3, 4, 32'h33, 32'h44, 32'h33, 32'hBBBB, 0, "R4 alu");
        mem_is_load = 1; mem_load_data = 32'hCCCC; mem_alu = 32'h1000;
        apply(4, 3, 32'h44, 32'h33, 32'hCCCC, 32'h33, 0, "R4 load");
        clear_taps();

        // R5: distance two, both writeback taps
        wb_we = 1; wb_rd = 5; wb_data = 32'h5555;
        ret_we = 1; ret_rd = 6; ret_data = 32'h6666;
        apply(5, 6, 32'h50, 32'h60, 32'h5555, 32'h6666, 0, "R5");
        clear_taps();

        // R6: same register in flight in every stage, peel youngest away
        ex_we = 1; ex_rd = 7; ex_result = 32'hE7;
        mem_we = 1; mem_rd = 7; mem_alu = 32'hA7;
        wb_we = 1; wb_rd = 7; wb_data = 32'hB7;
        ret_we = 1; ret_rd = 7; ret_data = 32'hC7;
        apply(7, 7, 32'h77, 32'h77, 32'hE7, 32'hE7, 0, "R6 ex");
        ex_we = 0;
        apply(7, 7, 32'h77, 32'h77, 32'hA7, 32'hA7, 0, "R6 mem");
        mem_we = 0;
        apply(7, 7, 32'h77, 32'h77, 32'hB7, 32'hB7, 0, "R6 wb");
        wb_we = 0;
        apply(7, 7, 32'h77, 32'h77, 32'hC7, 32'hC7, 0, "R6 ret");
        ret_we = 0;
        apply(7, 7, 32'h77, 32'h77, 32'h77, 32'h77, 0, "R6 rf");
        clear_taps();

        // R1: reserved ID never matches, load to reg 0 never stalls (R8)
        ex_we = 1; ex_is_load = 1; ex_rd = 0; ex_result = 32'hF0;
        mem_we = 1; mem_rd = 0; mem_alu = 32'hF1;
        wb_we = 1; wb_rd = 0; wb_data = 32'hF2;
        ret_we = 1; ret_rd = 0; ret_data = 32'hF3;
        apply(0, 0, 32'h0, 32'h0, 32'h0, 32'h0, 0, "R1");
        ex_is_load = 0;
        apply(0, 0, 32'h0, 32'h0, 32'h0, 32'h0, 0, "R1 alu");
        clear_taps();

        // R7: load-use with an older tap also matching
        ex_we = 1; ex_is_load = 1; ex_rd = 8; ex_result = 32'h1000;
        mem_we = 1; mem_rd = 8; mem_alu = 32'h8888;
        apply(8, 9, 32'h80, 32'h90, 32'h8888, 32'h90, 1, "R7 a");
        mem_we = 0;
        apply(9, 8, 32'h90, 32'h80, 32'h90, 32'h80, 1, "R7 b");
        // R8: load in execute, no source match
        apply(9, 10, 32'h90, 32'hA0, 32'h90, 32'hA0, 0, "R8 nomatch");
        // R8: non-load producer forwards without stall
        ex_is_load = 0;
        apply(8, 9, 32'h80, 32'h90, 32'h1000, 32'h90, 0, "R8 alu");
        // R8: load not writing
        ex_is_load = 1; ex_we = 0;
        apply(8, 8, 32'h80, 32'h80, 32'h80, 32'h80, 0, "R8 we0");
        clear_taps();

        // R9: operands from different taps in one cycle
        ex_we = 1; ex_rd = 11; ex_result = 32'h1111;
        mem_we = 1; mem_rd = 12; mem_alu = 32'h1212;
        apply(12, 11, 32'hC0, 32'hB0, 32'h1212, 32'h1111, 0, "R9");
        clear_taps();

        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule